// File: doc/BRIEF.md
# Locked Command Mailbox Controller

This block lets a requester hand a command and a word payload to a receiver across a shared buffer and collect a reply. Each side reaches the mailbox through its own plain register port: select, write strobe, 3-bit register address and data. Read data is combinational in the access cycle, and all side effects take place at the clock edge that ends the access.

Ownership moves through four states. The requester takes the mailbox by reading the lock register. That read is also the acquire. It then fills in the command, the byte length and the payload, and sets the execute bit, which passes the mailbox to the receiver and raises `data_avail`. The receiver drains the payload, may write a reply and its length, and writes a status code to give the mailbox back. The requester reads the reply when the status says data is ready. It then clears execute, and clearing execute is the only thing that frees the lock.

Register map (both ports): 0 lock (bit 0), 1 command, 2 byte length, 3 payload in (write), 4 payload out (read), 5 execute (bit 0), 6 status (bits 1:0), 7 present state (bits 2:0: 0 idle, 1 requester filling, 2 receiver executing, 3 reply to requester). Reads of address 3 return zero.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, the state reads 0, lock reads 0, status reads 00 and `data_avail` is low.
- R2: A requester read of address 0 while the mailbox is free returns 0 and claims it: the state becomes 1 (requester filling) and later lock reads return 1.
- R3: A lock read while the mailbox is held returns 1 and changes nothing. A receiver-side read of address 0 never claims the mailbox.
- R4: The command register (address 1) is written only by the requester in state 1. The length register (address 2) is written only by the side that currently owns the mailbox. Both are readable from either side at any time.
- R5: Payload-in writes (address 3) from the owning side fill consecutive buffer words starting at word 0. Writes from the side that does not own the mailbox are ignored, and writes past the last of DEPTH words are dropped.
- R6: A requester write of 1 to execute (address 5, bit 0) in state 1 moves the state to 2, resets status to 00 and raises `data_avail`. Execute then reads 1.
- R7: Payload-out reads (address 4) by the owning side return buffer words in order. Word k carries data only while 4*k is below the length register and k < DEPTH, and returns 0 otherwise. Payload-out reads by the non-owner return 0 and do not advance.
- R8: A receiver write to status (address 6, bits 1:0; 00 busy, 01 data ready, 10 complete, 11 failed) in state 2 stores the code, moves the state to 3 and drops `data_avail`. Status writes in any other state are ignored.
- R9: The requester's payload-out reads return data only in state 3 with status 01, and return 0 otherwise.
- R10: A requester write of 0 to execute in any held state returns the state to 0 and frees the lock. It wins over a status write made in the same cycle.
- R11: The payload-in and payload-out word positions both restart at word 0 whenever the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_sel | input | 1 | Requester access this cycle |
| req_wr | input | 1 | Requester access is a write |
| req_addr | input | 3 | Requester register address |
| req_wdata | input | DW | Requester write data |
| req_rdata | output | DW | Requester read data |
| rcv_sel | input | 1 | Receiver access this cycle |
| rcv_wr | input | 1 | Receiver access is a write |
| rcv_addr | input | 3 | Receiver register address |
| rcv_wdata | input | DW | Receiver write data |
| rcv_rdata | output | DW | Receiver read data |
| data_avail | output | 1 | Mailbox holds a command for the receiver |

## Verification
The bench goes after the payload edges. A byte length that is not a word multiple must still return its partial last word and then zeros; an off-by-one in the length test would cut that word or leak a stale one. A fifth write into a four-word buffer must be dropped; a design whose write position wrapped would overwrite word 0, and a later drain shows it. Every status code is swept to confirm that only 01 opens the reply to the requester and that each code moves the state. Writes from the wrong side are checked by reading back what they could have corrupted, and a release that arrives in the same cycle as a hand-back must win over it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_REQ_WRITE = 3'd1,
      ST_EXEC_RCVR = 3'd2,
      ST_EXEC_REQ  = 3'd3
   } mbx_state_e;

   localparam int unsigned REG_AW = 3;

   localparam logic [REG_AW-1:0] A_LOCK  = 3'd0;
   localparam logic [REG_AW-1:0] A_CMD   = 3'd1;
   localparam logic [REG_AW-1:0] A_DLEN  = 3'd2;
   localparam logic [REG_AW-1:0] A_DIN   = 3'd3;
   localparam logic [REG_AW-1:0] A_DOUT  = 3'd4;
   localparam logic [REG_AW-1:0] A_EXEC  = 3'd5;
   localparam logic [REG_AW-1:0] A_STAT  = 3'd6;
   localparam logic [REG_AW-1:0] A_STATE = 3'd7;

   localparam logic [1:0] MBX_BUSY = 2'd0;
   localparam logic [1:0] MBX_DATA = 2'd1;
   localparam logic [1:0] MBX_DONE = 2'd2;
   localparam logic [1:0] MBX_FAIL = 2'd3;

endpackage

// File: rtl/mbx_buffer.sv
module mbx_buffer #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ridx,
   output logic [DW-1:0] rdata
);

   logic [DEPTH-1:0][DW-1:0] words;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (we && (widx == AW'(i)))
            word_q <= wdata;
      end
      assign words[i] = word_q;
   end

   assign rdata = words[ridx];

endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
   import mbx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acquire,
   input  logic       exec_set,
   input  logic       exec_clr,
   input  logic       hand_back,
   output mbx_state_e state_q,
   output mbx_state_e state_d
);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (acquire) state_d = ST_REQ_WRITE;
         default: begin
            if (exec_clr)       state_d = ST_IDLE;
            else if (exec_set)  state_d = ST_EXEC_RCVR;
            else if (hand_back) state_d = ST_EXEC_REQ;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
   import mbx_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_sel,
   input  logic              req_wr,
   input  logic [REG_AW-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic [DW-1:0]     req_rdata,
   input  logic              rcv_sel,
   input  logic              rcv_wr,
   input  logic [REG_AW-1:0] rcv_addr,
   input  logic [DW-1:0]     rcv_wdata,
   output logic [DW-1:0]     rcv_rdata,
   output logic              data_avail
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned PW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] PTR_END = PW'(DEPTH);

   initial begin
      assert (DW >= 16) else $fatal(1, "mbx_ctrl: DW must be at least 16");
      assert (DEPTH >= 2) else $fatal(1, "mbx_ctrl: DEPTH must be at least 2");
   end

   mbx_state_e state_q, state_d;
   logic [DW-1:0] cmd_q, dlen_q;
   logic [1:0]    status_q;
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [DW-1:0] buf_word, dout_word;

   logic req_rd, req_we, rcv_rd, rcv_we;
   logic req_owns, rcv_owns;
   logic acquire, exec_set, exec_clr, hand_back;
   logic din_we, dout_req, dout_rcv, in_range, ptr_clr;

   assign req_rd = req_sel & ~req_wr;
   assign req_we = req_sel &  req_wr;
   assign rcv_rd = rcv_sel & ~rcv_wr;
   assign rcv_we = rcv_sel &  rcv_wr;

   assign req_owns = (state_q == ST_REQ_WRITE) || (state_q == ST_EXEC_REQ);
   assign rcv_owns = (state_q == ST_EXEC_RCVR);

   assign acquire   = req_rd && (req_addr == A_LOCK) && (state_q == ST_IDLE);
   assign exec_set  = req_we && (req_addr == A_EXEC) && req_wdata[0] && (state_q == ST_REQ_WRITE);
   assign exec_clr  = req_we && (req_addr == A_EXEC) && !req_wdata[0] && (state_q != ST_IDLE);
   assign hand_back = rcv_we && (rcv_addr == A_STAT) && rcv_owns && !exec_clr;

   mbx_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .acquire  (acquire),
      .exec_set (exec_set),
      .exec_clr (exec_clr),
      .hand_back(hand_back),
      .state_q  (state_q),
      .state_d  (state_d)
   );

   assign ptr_clr = (state_d != state_q);

   assign din_we = (wr_ptr < PTR_END) &&
                   ((req_we && (req_addr == A_DIN) && req_owns) ||
                    (rcv_we && (rcv_addr == A_DIN) && rcv_owns));

   assign dout_req = req_rd && (req_addr == A_DOUT) &&
                     (state_q == ST_EXEC_REQ) && (status_q == MBX_DATA);
   assign dout_rcv = rcv_rd && (rcv_addr == A_DOUT) && rcv_owns;

   mbx_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (din_we),
      .widx (wr_ptr[AW-1:0]),
      .wdata(rcv_owns ? rcv_wdata : req_wdata),
      .ridx (rd_ptr[AW-1:0]),
      .rdata(buf_word)
   );

   assign in_range  = (rd_ptr < PTR_END) && ((DW'(rd_ptr) << 2) < dlen_q);
   assign dout_word = in_range ? buf_word : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (ptr_clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (din_we) wr_ptr <= wr_ptr + PW'(1);
         if ((dout_req || dout_rcv) && (rd_ptr < PTR_END)) rd_ptr <= rd_ptr + PW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         dlen_q   <= '0;
         status_q <= MBX_BUSY;
      end else begin
         if (req_we && (req_addr == A_CMD) && (state_q == ST_REQ_WRITE))
            cmd_q <= req_wdata;
         if (req_we && (req_addr == A_DLEN) && req_owns)
            dlen_q <= req_wdata;
         else if (rcv_we && (rcv_addr == A_DLEN) && rcv_owns)
            dlen_q <= rcv_wdata;
         if (exec_set)
            status_q <= MBX_BUSY;
         else if (hand_back)
            status_q <= rcv_wdata[1:0];
      end
   end

   always_comb begin
      unique case (req_addr)
         A_LOCK:  req_rdata = DW'(state_q != ST_IDLE);
         A_CMD:   req_rdata = cmd_q;
         A_DLEN:  req_rdata = dlen_q;
         A_DOUT:  req_rdata = dout_req ? dout_word : '0;
         A_EXEC:  req_rdata = DW'((state_q == ST_EXEC_RCVR) || (state_q == ST_EXEC_REQ));
         A_STAT:  req_rdata = DW'(status_q);
         A_STATE: req_rdata = DW'(state_q);
         default: req_rdata = '0;
      endcase
   end

   always_comb begin
      unique case (rcv_addr)
         A_LOCK:  rcv_rdata = DW'(state_q != ST_IDLE);
         A_CMD:   rcv_rdata = cmd_q;
         A_DLEN:  rcv_rdata = dlen_q;
         A_DOUT:  rcv_rdata = dout_rcv ? dout_word : '0;
         A_EXEC:  rcv_rdata = DW'((state_q == ST_EXEC_RCVR) || (state_q == ST_EXEC_REQ));
         A_STAT:  rcv_rdata = DW'(status_q);
         A_STATE: rcv_rdata = DW'(state_q);
         default: rcv_rdata = '0;
      endcase
   end

   assign data_avail = rcv_owns;

endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_sel,
   input logic          req_wr,
   input logic [2:0]    req_addr,
   input logic [DW-1:0] req_wdata,
   input logic [DW-1:0] req_rdata,
   input logic          rcv_sel,
   input logic          rcv_wr,
   input logic [2:0]    rcv_addr,
   input logic [DW-1:0] rcv_wdata,
   input logic [DW-1:0] rcv_rdata,
   input logic          data_avail,
   input logic [2:0]    state_q,
   input logic [1:0]    status_q
);

   logic req_clr;
   assign req_clr = req_sel && req_wr && (req_addr == 3'd5) && !req_wdata[0];

   // R2
   lock_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sel && !req_wr && (req_addr == 3'd0) && (req_rdata[0] == 1'b0))
      |=> (state_q == 3'd1));

   // R3
   lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sel && !req_wr && (req_addr == 3'd0) && req_rdata[0])
      |=> (state_q != 3'd0));

   // R6
   exec_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_avail) |-> ($past(req_sel && req_wr && (req_addr == 3'd5) && req_wdata[0])
                              && (status_q == 2'd0)));

   // R7
   dout_nonowner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_sel && !rcv_wr && (rcv_addr == 3'd4) && !data_avail) |-> (rcv_rdata == '0));

   // R8
   hand_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_sel && rcv_wr && (rcv_addr == 3'd6) && data_avail && !req_clr)
      |=> ((state_q == 3'd3) && (status_q == $past(rcv_wdata[1:0]))));

   // R9
   dout_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sel && !req_wr && (req_addr == 3'd4) && (status_q != 2'd1)) |-> (req_rdata == '0));

   // R10
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_clr && (state_q != 3'd0)) |=> ((state_q == 3'd0) && !data_avail));

endmodule

bind mbx_ctrl mbx_ctrl_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_sel   (req_sel),
   .req_wr    (req_wr),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .req_rdata (req_rdata),
   .rcv_sel   (rcv_sel),
   .rcv_wr    (rcv_wr),
   .rcv_addr  (rcv_addr),
   .rcv_wdata (rcv_wdata),
   .rcv_rdata (rcv_rdata),
   .data_avail(data_avail),
   .state_q   (state_q),
   .status_q  (status_q)
);

// File: tb/mbx_ctrl_test.sv
`timescale 1ns/1ps
module mbx_ctrl_test;

   localparam int DW    = 32;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_sel = 1'b0, req_wr = 1'b0;
   logic [2:0]    req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] req_rdata;
   logic          rcv_sel = 1'b0, rcv_wr = 1'b0;
   logic [2:0]    rcv_addr = '0;
   logic [DW-1:0] rcv_wdata = '0;
   logic [DW-1:0] rcv_rdata;
   logic          data_avail;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mbx_ctrl #(.DW(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_sel(req_sel), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_rdata(req_rdata),
      .rcv_sel(rcv_sel), .rcv_wr(rcv_wr), .rcv_addr(rcv_addr),
      .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
      .data_avail(data_avail)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rq(input bit wr, input logic [2:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] r);
      @(negedge clk);
      req_sel = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      #1 r = req_rdata;
      @(posedge clk);
      #1 req_sel = 1'b0; req_wr = 1'b0;
   endtask

   task automatic rv(input bit wr, input logic [2:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] r);
      @(negedge clk);
      rcv_sel = 1'b1; rcv_wr = wr; rcv_addr = a; rcv_wdata = d;
      #1 r = rcv_rdata;
      @(posedge clk);
      #1 rcv_sel = 1'b0; rcv_wr = 1'b0;
   endtask

   task automatic rq_chk(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
      logic [DW-1:0] r;
      rq(1'b0, a, '0, r);
      chk(tag, r, exp);
   endtask

   task automatic rv_chk(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
      logic [DW-1:0] r;
      rv(1'b0, a, '0, r);
      chk(tag, r, exp);
   endtask

   task automatic rq_w(input logic [2:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] r;
      rq(1'b1, a, d, r);
   endtask

   task automatic rv_w(input logic [2:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] r;
      rv(1'b1, a, d, r);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rv_chk(3'd7, 0, "R1 state");
      rv_chk(3'd6, 0, "R1 status");
      chk("R1 data_avail", DW'(data_avail), 0);
      // R3 receiver lock read does not claim
      rv_chk(3'd0, 0, "R3 rcv lock read");
      rv_chk(3'd7, 0, "R3 state after rcv lock read");

      // R2 acquire
      rq_chk(3'd0, 0, "R2 acquire returns 0");
      rq_chk(3'd7, 1, "R2 state filling");
      // R3 held lock reads 1
      rq_chk(3'd0, 1, "R3 held lock");
      rq_chk(3'd7, 1, "R3 state unchanged");

      // R5 non-owner write ignored, R4 command access
      rv_w(3'd3, 32'hBAD0_BAD0);
      rv_w(3'd1, 32'h55);
      rq_w(3'd1, 32'hA5);
      rv_chk(3'd1, 32'hA5, "R4 command");
      rq_w(3'd2, 10);
      rv_chk(3'd2, 10, "R4 length");
      // R9 no reply data while filling
      rq_chk(3'd4, 0, "R9 dout while filling");
      for (int i = 0; i < DEPTH + 1; i++) rq_w(3'd3, 32'h1000 + i);

      // R6 execute
      rq_w(3'd5, 1);
      rq_chk(3'd7, 2, "R6 state exec");
      chk("R6 data_avail", DW'(data_avail), 1);
      rq_chk(3'd6, 0, "R6 status busy");
      rq_chk(3'd5, 1, "R6 execute bit");
      rv_w(3'd1, 32'h77);
      rq_chk(3'd1, 32'hA5, "R4 command locked in exec");
      rq_w(3'd2, 99);
      rv_chk(3'd2, 10, "R4 non-owner length ignored");
      rq_w(3'd3, 32'hDEAD);

      // R7 / R11 drain: 10 bytes -> 3 words then zero
      rq_chk(3'd4, 0, "R7 non-owner dout");
      for (int k = 0; k < 4; k++)
         rv_chk(3'd4, (4 * k < 10) ? 32'h1000 + k : 0, $sformatf("R7 R11 drain word %0d", k));

      // R8 reply
      rv_w(3'd2, 8);
      rv_w(3'd3, 32'h2000);
      rv_w(3'd3, 32'h2001);
      rv_w(3'd6, 1);
      rq_chk(3'd7, 3, "R8 state reply");
      chk("R8 data_avail low", DW'(data_avail), 0);
      rq_chk(3'd6, 1, "R8 status data ready");
      rv_chk(3'd4, 0, "R7 receiver non-owner dout");
      for (int k = 0; k < 3; k++)
         rq_chk(3'd4, (k < 2) ? 32'h2000 + k : 0, $sformatf("R9 reply word %0d", k));

      // R10 release
      rq_w(3'd5, 0);
      rq_chk(3'd7, 0, "R10 idle after release");
      rv_chk(3'd0, 0, "R10 lock free");
      rv_w(3'd6, 2);
      rq_chk(3'd6, 1, "R8 status write ignored when idle");

      // R8 R9 sweep of every status code
      for (int c = 0; c < 4; c++) begin
         rq_chk(3'd0, 0, $sformatf("R2 acquire code %0d", c));
         rq_w(3'd2, 4);
         rq_w(3'd3, 32'h3000 + c);
         rq_w(3'd5, 1);
         rv_chk(3'd4, 32'h3000 + c, $sformatf("R7 word code %0d", c));
         rv_w(3'd6, c);
         rq_chk(3'd7, 3, $sformatf("R8 state code %0d", c));
         rq_chk(3'd6, c, $sformatf("R8 status code %0d", c));
         rq_chk(3'd4, (c == 1) ? 32'h3000 + c : 0, $sformatf("R9 gated dout code %0d", c));
         rq_w(3'd5, 0);
         rq_chk(3'd7, 0, $sformatf("R10 release code %0d", c));
      end

      // R5 depth overflow: fifth write dropped, word 0 intact
      rq_chk(3'd0, 0, "R2 acquire overflow run");
      rq_w(3'd2, 20);
      for (int i = 0; i < DEPTH + 1; i++) rq_w(3'd3, 32'h40 + i);
      rq_w(3'd5, 1);
      for (int k = 0; k < DEPTH + 1; k++)
         rv_chk(3'd4, (k < DEPTH) ? 32'h40 + k : 0, $sformatf("R5 overflow word %0d", k));
      rq_w(3'd5, 0);

      // R10 abort straight from filling
      rq_chk(3'd0, 0, "R2 acquire abort run");
      rq_w(3'd5, 0);
      rq_chk(3'd7, 0, "R10 abort from filling");

      // R10 release wins over simultaneous hand-back
      rq_chk(3'd0, 0, "R2 acquire race run");
      rq_w(3'd5, 1);
      @(negedge clk);
      req_sel = 1'b1; req_wr = 1'b1; req_addr = 3'd5; req_wdata = 0;
      rcv_sel = 1'b1; rcv_wr = 1'b1; rcv_addr = 3'd6; rcv_wdata = 1;
      @(posedge clk);
      #1 req_sel = 1'b0; req_wr = 1'b0; rcv_sel = 1'b0; rcv_wr = 1'b0;
      rq_chk(3'd7, 0, "R10 release priority state");
      rq_chk(3'd6, 0, "R10 release priority status");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule